// File: doc/BRIEF.md
# Exception Priority Arbiter

This block chooses which of a set of exception sources is presented to a processor core next. There are 62 sources: eight trap slots with fixed levels at the top of the level range, and 54 interrupt lines. Each interrupt has its own enable bit and a 3-bit software priority. Each source rises into a pending register. On every clock the arbiter looks at the pending set, gives each entry a level, keeps only entries whose level is above the core's current running level, and picks the highest. When levels are equal, the lowest vector number wins.

The winner's vector number and level are registered. When there is a winner, a request flag goes high. The core answers with an acknowledge. That clears the presented source's pending bit, and the core adopts the reported level as its new running level. Table fetch, context save and the return path belong to other blocks.

A two-state controller drives the request flag. In IDLE no request is shown. The transition RAISE (a winner exists) moves it to REQUEST. In REQUEST the request flag is high and the registered vector may be retargeted each cycle (transition RETARGET) when a higher-level source arrives. The transition WITHDRAW returns it to IDLE when no qualifying source remains, whether because of an acknowledge or because the running level rose.

Top module: `exc_arb`

## Requirements
- R1: Trap slot t (0..7) reports vector t. Interrupt line k (0..53) reports vector 8+k. `vec_o` is 6 bits wide.
- R2: Trap slot t has the fixed level 15-t. Every trap level is above every interrupt level.
- R3: Trap slots 0, 5, 6 and 7 are reserved (parameter mask 8'hE1, bit t = slot t). A source on a reserved slot never becomes pending and never produces a request.
- R4: The level of interrupt k is its priority field `irq_prio_i[3k+2:3k]`, but only while `irq_en_i[k]` is 1. A disabled line, or a line with priority 0, never requests. Its pending bit stays latched and can request once it becomes eligible.
- R5: Among qualifying sources with equal level, the one with the lowest vector number is presented.
- R6: A request is shown only when the winner's level is strictly greater than `cpu_ipl_i`. With `cpu_ipl_i` = 15, nothing is requested.
- R7: Source inputs are sampled as levels and latched into pending bits on each clock edge. The arbitration result for the inputs present before an edge appears on `req_o`, `vec_o` and `new_ipl_o` right after that edge (one clock of latency).
- R8: `ack_i` high while `req_o` is high clears the pending bit of the vector on `vec_o`. The clear takes effect on the same edge, and the clear wins over a source still high in that cycle. A source held high becomes pending again on the following edge.
- R9: `ack_i` while `req_o` is low has no effect on any pending bit.
- R10: After reset, `req_o`, `vec_o` and `new_ipl_o` are 0. While a request is shown, `new_ipl_o` equals the winner's level. While none is shown, `vec_o` and `new_ipl_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_src_i | input | 8 | Trap source levels, bit t = slot t |
| irq_src_i | input | 54 | Interrupt source levels, bit k = line k |
| irq_en_i | input | 54 | Per-line interrupt enable |
| irq_prio_i | input | 162 | Packed 3-bit priorities, line k at bits [3k+2:3k] |
| cpu_ipl_i | input | 4 | Current running level of the core |
| ack_i | input | 1 | Acknowledge of the presented vector |
| req_o | output | 1 | Exception request |
| vec_o | output | 6 | Presented vector number |
| new_ipl_o | output | 4 | Level the core adopts on acknowledge |

## Verification
The assertions assume that `cpu_ipl_i`, the enables and the priorities are stable over each clock edge, and that the reserved-slot mask is the one the design was built with. They compare `new_ipl_o` against the running level seen one edge earlier. For that reason they also assume that the running level is driven to a defined value from the first clock. The bench drives every input on the falling edge, holds a known running level from time zero, and keeps the reserved mask at its default. It then sweeps each line, each trap slot, full-tie drains and pseudo-random mixes against an arithmetic model of the level rules.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_REQUEST = 1'b1
    } arb_state_e;

endpackage

// File: rtl/exc_pend.sv
module exc_pend #(
    parameter int unsigned N = 62
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] eff_o
);

    logic [N-1:0] pend_q;

    // Sources fold into the latched set; an acknowledge clear takes priority
    assign eff_o = (pend_q | src_i) & ~clr_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= eff_o;
        end
    end

endmodule

// File: rtl/exc_level.sv
module exc_level #(
    parameter int unsigned N_TRAP = 8,
    parameter int unsigned N_IRQ  = 54,
    parameter int unsigned PRIO_W = 3
) (
    input  logic [N_TRAP+N_IRQ-1:0]          eff_i,
    input  logic [N_IRQ-1:0]                 en_i,
    input  logic [N_IRQ*PRIO_W-1:0]          prio_i,
    output logic [(N_TRAP+N_IRQ)*(PRIO_W+1)-1:0] lvl_o
);

    localparam int unsigned LVL_W   = PRIO_W + 1;
    localparam int unsigned LVL_MAX = (1 << LVL_W) - 1;

    // Trap slots: fixed levels, counting down from the top of the range
    for (genvar t = 0; t < N_TRAP; t++) begin : g_trap
        assign lvl_o[t*LVL_W +: LVL_W] = eff_i[t] ? LVL_W'(LVL_MAX - t) : '0;
    end

    // Interrupt lines: programmed priority, gated by enable
    for (genvar k = 0; k < N_IRQ; k++) begin : g_irq
        assign lvl_o[(N_TRAP+k)*LVL_W +: LVL_W] =
            (eff_i[N_TRAP+k] && en_i[k]) ? {1'b0, prio_i[k*PRIO_W +: PRIO_W]} : '0;
    end

endmodule

// File: rtl/exc_select.sv
module exc_select #(
    parameter int unsigned N     = 62,
    parameter int unsigned LVL_W = 4,
    parameter int unsigned IDX_W = 6
) (
    input  logic [N*LVL_W-1:0] lvl_i,
    input  logic [LVL_W-1:0]   ipl_i,
    output logic               valid_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [LVL_W-1:0]   lvl_o
);

    always_comb begin
        logic [LVL_W-1:0] cand;
        valid_o = 1'b0;
        idx_o   = '0;
        lvl_o   = '0;
        // Downward scan with >= leaves the lowest index on a tie
        for (int i = N - 1; i >= 0; i--) begin
            cand = lvl_i[i*LVL_W +: LVL_W];
            if ((cand > ipl_i) && (cand >= lvl_o)) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
                lvl_o   = cand;
            end
        end
    end

endmodule

// File: rtl/exc_arb.sv
module exc_arb
    import exc_arb_pkg::*;
#(
    parameter int unsigned       N_TRAP    = 8,
    parameter int unsigned       N_IRQ     = 54,
    parameter int unsigned       PRIO_W    = 3,
    parameter logic [N_TRAP-1:0] TRAP_RSVD = 8'hE1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [N_TRAP-1:0]                   trap_src_i,
    input  logic [N_IRQ-1:0]                    irq_src_i,
    input  logic [N_IRQ-1:0]                    irq_en_i,
    input  logic [N_IRQ*PRIO_W-1:0]             irq_prio_i,
    input  logic [PRIO_W:0]                     cpu_ipl_i,
    input  logic                                ack_i,
    output logic                                req_o,
    output logic [$clog2(N_TRAP+N_IRQ)-1:0]     vec_o,
    output logic [PRIO_W:0]                     new_ipl_o
);

    localparam int unsigned N_SRC = N_TRAP + N_IRQ;
    localparam int unsigned VEC_W = $clog2(N_SRC);
    localparam int unsigned LVL_W = PRIO_W + 1;

    arb_state_e         state_q, state_d;
    logic [VEC_W-1:0]   vec_q, vec_d;
    logic [LVL_W-1:0]   ipl_q, ipl_d;

    logic [N_SRC-1:0]       src_all;
    logic [N_SRC-1:0]       clr;
    logic [N_SRC-1:0]       eff;
    logic [N_SRC*LVL_W-1:0] lvl;
    logic                   win_valid;
    logic [VEC_W-1:0]       win_idx;
    logic [LVL_W-1:0]       win_lvl;
    logic                   ack_ok;

    // Reserved trap slots are blocked before they can latch
    assign src_all = {irq_src_i, trap_src_i & ~TRAP_RSVD};
    assign ack_ok  = ack_i && (state_q == ST_REQUEST);
    assign clr     = ack_ok ? (N_SRC'(1) << vec_q) : '0;

    exc_pend #(.N(N_SRC)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (src_all),
        .clr_i (clr),
        .eff_o (eff)
    );

    exc_level #(.N_TRAP(N_TRAP), .N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_level (
        .eff_i  (eff),
        .en_i   (irq_en_i),
        .prio_i (irq_prio_i),
        .lvl_o  (lvl)
    );

    exc_select #(.N(N_SRC), .LVL_W(LVL_W), .IDX_W(VEC_W)) u_select (
        .lvl_i   (lvl),
        .ipl_i   (cpu_ipl_i),
        .valid_o (win_valid),
        .idx_o   (win_idx),
        .lvl_o   (win_lvl)
    );

    // Next state and output values
    always_comb begin
        state_d = state_q;
        vec_d   = '0;
        ipl_d   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (win_valid) state_d = ST_REQUEST;       // RAISE
            end
            ST_REQUEST: begin
                if (!win_valid) state_d = ST_IDLE;         // WITHDRAW
                else            state_d = ST_REQUEST;      // RETARGET
            end
            default: state_d = ST_IDLE;
        endcase
        if (win_valid) begin
            vec_d = win_idx;
            ipl_d = win_lvl;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
            ipl_q <= '0;
        end else begin
            vec_q <= vec_d;
            ipl_q <= ipl_d;
        end
    end

    assign req_o     = (state_q == ST_REQUEST);
    assign vec_o     = vec_q;
    assign new_ipl_o = ipl_q;

endmodule

// File: rtl/exc_arb_checker.sv
module exc_arb_checker #(
    parameter int unsigned       N_TRAP    = 8,
    parameter int unsigned       VEC_W     = 6,
    parameter int unsigned       LVL_W     = 4,
    parameter int unsigned       N_SRC     = 62,
    parameter logic [N_TRAP-1:0] TRAP_RSVD = 8'hE1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] cpu_ipl_i,
    input logic             req_o,
    input logic [VEC_W-1:0] vec_o,
    input logic [LVL_W-1:0] new_ipl_o
);

    localparam int unsigned LVL_MAX = (1 << LVL_W) - 1;

    // R1: presented vector lies inside the source range
    a_r1_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (int'(vec_o) < N_SRC));

    // R2: a presented trap carries its fixed level
    a_r2_trap_level: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && (int'(vec_o) < N_TRAP)) |-> (new_ipl_o == LVL_W'(LVL_MAX - int'(vec_o))));

    // R3: reserved trap slots are never presented
    a_r3_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && (int'(vec_o) < N_TRAP)) |-> (((TRAP_RSVD >> vec_o) & N_TRAP'(1)) == '0));

    // R4: an interrupt is presented at a programmable level 1..7
    a_r4_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && (int'(vec_o) >= N_TRAP)) |->
            ((new_ipl_o != '0) && (int'(new_ipl_o) < (1 << (LVL_W - 1)))));

    // R6: a request always outranks the running level seen at the prior edge
    a_r6_above_ipl: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (new_ipl_o > $past(cpu_ipl_i)));

endmodule

bind exc_arb exc_arb_checker #(
    .N_TRAP    (N_TRAP),
    .VEC_W     ($clog2(N_TRAP+N_IRQ)),
    .LVL_W     (PRIO_W+1),
    .N_SRC     (N_TRAP+N_IRQ),
    .TRAP_RSVD (TRAP_RSVD)
) u_exc_arb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ipl_i (cpu_ipl_i),
    .req_o     (req_o),
    .vec_o     (vec_o),
    .new_ipl_o (new_ipl_o)
);

// File: tb/test_exc_arb.sv
module test_exc_arb;

    localparam int NT = 8;
    localparam int NI = 54;
    localparam int NS = NT + NI;
    localparam logic [NT-1:0] RSVD = 8'hE1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NT-1:0]   trap_src = '0;
    logic [NI-1:0]   irq_src = '0;
    logic [NI-1:0]   irq_en = '0;
    logic [NI*3-1:0] irq_prio;
    logic [3:0]      cpu_ipl = '0;
    logic            ack = 1'b0;
    logic            req_o;
    logic [5:0]      vec_o;
    logic [3:0]      new_ipl_o;

    logic [2:0] prio [NI];

    always_comb begin
        for (int k = 0; k < NI; k++) irq_prio[k*3 +: 3] = prio[k];
    end

    always #4 clk = ~clk;

    exc_arb i_exc_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .trap_src_i (trap_src),
        .irq_src_i  (irq_src),
        .irq_en_i   (irq_en),
        .irq_prio_i (irq_prio),
        .cpu_ipl_i  (cpu_ipl),
        .ack_i      (ack),
        .req_o      (req_o),
        .vec_o      (vec_o),
        .new_ipl_o  (new_ipl_o)
    );

    int n_chk  = 0;
    int n_fail = 0;
    logic [NS-1:0] m_pend = '0;
    bit  m_req = 0;
    int  m_vec = 0;
    int  m_ipl = 0;
    logic [31:0] lf = 32'h1D2C_3B4A;

    function automatic int level_of(int i, logic [NS-1:0] e);
        if (!e[i]) return 0;
        if (i < NT) return 15 - i;
        return irq_en[i-NT] ? int'(prio[i-NT]) : 0;
    endfunction

    task automatic step_lf();
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    endtask

    // Advance one clock and compare against the level-rule model
    task automatic tick(input string tag);
        logic [NS-1:0] e;
        int bl, bi, l;
        e = m_pend | {irq_src, trap_src & ~RSVD};
        if (ack && m_req) e[m_vec] = 1'b0;
        m_pend = e;
        bl = 0; bi = 0;
        for (int i = NS - 1; i >= 0; i--) begin
            l = level_of(i, e);
            if (l > int'(cpu_ipl) && l >= bl) begin bl = l; bi = i; end
        end
        m_req = (bl != 0);
        m_vec = m_req ? bi : 0;
        m_ipl = bl;
        @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (req_o !== m_req || int'(vec_o) !== m_vec || int'(new_ipl_o) !== m_ipl) begin
            n_fail++;
            $display("FAIL %s: req=%0b vec=%0d ipl=%0d expected req=%0b vec=%0d ipl=%0d",
                     tag, req_o, vec_o, new_ipl_o, m_req, m_vec, m_ipl);
        end
    endtask

    task automatic drain(input string tag);
        irq_src = '0; trap_src = '0; cpu_ipl = '0;
        irq_en = '1;
        for (int k = 0; k < NI; k++) prio[k] = 3'd7;
        ack = 1'b1;
        for (int n = 0; n < 80; n++) tick(tag);
        ack = 1'b0;
        tick(tag);
    endtask

    initial begin
        for (int k = 0; k < NI; k++) prio[k] = '0;
        repeat (3) @(negedge clk);
        // R10: reset values
        n_chk++;
        if (req_o !== 1'b0 || vec_o !== '0 || new_ipl_o !== '0) begin
            n_fail++;
            $display("FAIL R10 reset: req=%0b vec=%0d ipl=%0d expected 0 0 0", req_o, vec_o, new_ipl_o);
        end
        rst_n = 1'b1;
        tick("R10");

        // R1 R4 R6 R7: each line alone, priority and running level swept
        irq_en = '1;
        for (int k = 0; k < NI; k++) begin
            prio[k] = 3'((k % 7) + 1);
            cpu_ipl = 4'(k % 8);
            irq_src[k] = 1'b1;
            tick("R7");
            irq_src[k] = 1'b0;
            tick("R6");
            cpu_ipl = '0;
            tick("R1");
            ack = 1'b1;
            tick("R8");
            ack = 1'b0;
            tick("R4");
        end

        // R2 R3: each trap slot against a full set of level-7 interrupts
        for (int t = 0; t < NT; t++) begin
            for (int k = 0; k < NI; k++) prio[k] = 3'd7;
            irq_src = '1;
            trap_src[t] = 1'b1;
            cpu_ipl = 4'd7;
            tick("R3");
            irq_src = '0; trap_src = '0;
            tick("R2");
            cpu_ipl = 4'd15;
            tick("R6");
            cpu_ipl = 4'd7;
            ack = 1'b1;
            tick("R2");
            ack = 1'b0;
            drain("R5");
        end

        // R5: full tie drained one vector per acknowledge
        for (int k = 0; k < NI; k++) prio[k] = 3'd4;
        irq_src = '1;
        tick("R5");
        irq_src = '0;
        ack = 1'b1;
        for (int n = 0; n < NI + 2; n++) tick("R5");
        ack = 1'b0;

        // R9: acknowledge without a request is ignored
        prio[5] = 3'd3;
        cpu_ipl = 4'd5;
        irq_src[5] = 1'b1;
        tick("R9");
        irq_src[5] = 1'b0;
        ack = 1'b1;
        repeat (3) tick("R9");
        ack = 1'b0;
        cpu_ipl = '0;
        tick("R9");
        ack = 1'b1;
        tick("R9");
        ack = 1'b0;

        // R8: held source reappears after clear
        prio[2] = 3'd6;
        irq_src[2] = 1'b1;
        tick("R8");
        ack = 1'b1;
        tick("R8");
        ack = 1'b0;
        repeat (2) tick("R8");
        irq_src[2] = 1'b0;
        drain("R8");

        // R4: disabled and zero-priority lines
        irq_en = '0;
        prio[9] = 3'd7;
        prio[10] = 3'd0;
        irq_src[9] = 1'b1; irq_src[10] = 1'b1;
        tick("R4");
        irq_src = '0;
        tick("R4");
        irq_en[10] = 1'b1;
        tick("R4");
        irq_en[9] = 1'b1;
        tick("R4");
        drain("R4");

        // R5 R6 R8: pseudo-random mixes
        for (int r = 0; r < 40; r++) begin
            for (int k = 0; k < NI; k++) begin
                step_lf();
                prio[k] = lf[2:0];
                irq_en[k] = lf[5] | lf[6];
                irq_src[k] = lf[9] & lf[11];
            end
            step_lf();
            trap_src = lf[7:0] & {4'b0, lf[12], lf[13], lf[14], lf[15]};
            for (int c = 0; c < 6; c++) begin
                step_lf();
                cpu_ipl = {1'b0, lf[2:0]};
                ack = lf[4];
                tick("R5");
                irq_src = '0; trap_src = '0;
            end
            ack = 1'b0;
            drain("R6");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog (R7): actual run still active, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule